// File: doc/BRIEF.md
# SPI EEPROM Boot Record Loader

This block runs once after reset. On a start pulse it first looks at a strap input. A low strap means no serial EEPROM is fitted, so the loader flags the boot as skipped and leaves the SPI pins idle. A high strap makes the loader read a serial EEPROM as an SPI master in mode 0. The clock idles low, the master changes MOSI on falling edges and it samples MISO on rising edges. The loader opens with a probe: a read command, two zero address bytes and four data bytes.

The probe result fixes the EEPROM's address width:

- If the four bytes equal the signature word, the part uses 16-bit addressing.
- If only the last three equal the first three signature characters, the part is a 24-bit device. Such a device swallowed one read byte as its missing third address byte.
- If neither holds, the boot is skipped.

After the probe, the loader deselects the part and then reopens it at byte address 4 with the matching number of address bytes. It streams the rest of the image without a break. The image is a chain of self-describing records. Each record is a type byte, a 16-bit length (low byte first) and a 16-bit target address (low byte first), followed by the payload.

Types 0, 1 and 2 copy their payload to memory space 0, 1 or 2. The loader packs the bytes into 16-bit words and writes them to consecutive word addresses. Type 3 ends the boot and reports its address field as the start address. Every other type is stepped over using its length. A byte budget stops a runaway image with an error flag.

Top module: `spi_boot_loader`

## Requirements
- R1: When `boot_strap` is low at the start pulse, `skipped` rises, `spi_cs_n` stays high and no memory write occurs.
- R2: The first SPI transaction sends command byte 0x03 followed by two address bytes 0x00 0x00, in SPI mode 0 with MSB first. `spi_sclk` is low whenever `spi_cs_n` is high.
- R3: If the four probe bytes equal `SIGNATURE` (most significant byte first), a second transaction reads from byte address 4 using two address bytes.
- R4: If only the last three probe bytes equal the top three signature bytes, the second transaction reads from byte address 4 using three address bytes.
- R5: If neither probe match holds, `skipped` rises and no memory write occurs.
- R6: A record of type 0, 1 or 2 writes its payload to `mem_space` 0, 1 or 2. The first word goes to the record's target address, and the address rises by one per word.
- R7: The payload is packed two bytes per word, with the earlier byte in bits 7:0 and the later byte in bits 15:8. An odd final byte is written with bits 15:8 zero. `mem_we` is a single-cycle pulse.
- R8: A record whose type is above 3 produces no write, and parsing resumes after its payload. A type 0 to 2 record of length zero produces no write.
- R9: A type 3 record raises `done`, puts its address field on `exec_addr` and deselects the EEPROM. No write follows it.
- R10: If `MAX_BYTES` bytes are read after address 4 with no type 3 record, `error` rises and the EEPROM is deselected.
- R11: After reset, all outputs are low except `spi_cs_n`, which is high. At most one of `done`, `skipped` and `error` is ever set, and it stays set until reset; further start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins the boot attempt |
| boot_strap | input | 1 | High enables the EEPROM boot |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | EEPROM select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| mem_space | output | 2 | Target space of the write: 0, 1 or 2 |
| mem_addr | output | 16 | Word address of the write |
| mem_data | output | 16 | Packed payload word |
| mem_we | output | 1 | Write strobe, one cycle per word |
| done | output | 1 | Execute record reached |
| skipped | output | 1 | Boot abandoned by strap or signature |
| error | output | 1 | Byte budget exhausted |
| exec_addr | output | 16 | Start address from the execute record |

## Verification
The bench builds the loader with `SCLK_HALF` = 2, `CS_GAP` = 3 and `MAX_BYTES` = 64. The small byte budget lets an image with a 200-byte unknown record hit the abort path within a few thousand cycles. Each image is served by an EEPROM model that runs in either 16-bit or 24-bit address mode. Running every image in both modes exercises the one-byte-shifted signature path, and the record walk is then checked identically for both address widths.

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter logic [31:0] SIGNATURE = 32'h4254_4C44,
  parameter int SCLK_HALF = 4,
  parameter int CS_GAP    = 4,
  parameter int MAX_BYTES = 65536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        boot_strap,
  input  logic        spi_miso,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  output logic [1:0]  mem_space,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_data,
  output logic        mem_we,
  output logic        done,
  output logic        skipped,
  output logic        error,
  output logic [15:0] exec_addr
);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PROBE, ST_GAP, ST_REC, ST_END} st_t;
  st_t st;

  logic [DIV_W-1:0] div;
  logic             busy, sclk_q, bdone;
  logic [2:0]       bitn;
  logic [7:0]       txr, rxr, next_tx;
  logic [1:0]       hidx, hlast, pcnt;
  logic             probing, a24, half;
  logic [23:0]      pr;
  logic [GAP_W-1:0] gap;
  logic [2:0]       fld;
  logic [7:0]       rtype, alo, lo;
  logic [15:0]      rlen, waddr;
  logic [CNT_W-1:0] nbytes;

  assign hlast    = a24 ? 2'd3 : 2'd2;
  assign next_tx  = (st != ST_HDR) ? 8'h00 :
                    (hidx == 2'd0) ? 8'h03 :
                    (!probing && hidx == hlast) ? 8'h04 : 8'h00;
  wire   tick     = busy && (div == DIV_W'(SCLK_HALF - 1));
  wire   kick     = !busy && !bdone && (st == ST_HDR || st == ST_PROBE || st == ST_REC);
  assign spi_sclk = sclk_q;
  assign spi_mosi = txr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; busy <= 1'b0; sclk_q <= 1'b0; bdone <= 1'b0;
      bitn <= '0; txr <= '0; rxr <= '0;
    end else begin
      bdone <= 1'b0;
      if (kick) begin
        busy <= 1'b1; txr <= next_tx; bitn <= '0; div <= '0;
      end else if (busy) begin
        div <= tick ? '0 : DIV_W'(div + 1'b1);
        if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rxr    <= {rxr[6:0], spi_miso};
          end else begin
            sclk_q <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0; bdone <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              txr  <= {txr[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; spi_cs_n <= 1'b1; hidx <= '0; pcnt <= '0;
      probing <= 1'b0; a24 <= 1'b0; half <= 1'b0; pr <= '0; gap <= '0;
      fld <= '0; rtype <= '0; alo <= '0; lo <= '0; rlen <= '0; waddr <= '0;
      nbytes <= '0; mem_space <= '0; mem_addr <= '0; mem_data <= '0;
      mem_we <= 1'b0; done <= 1'b0; skipped <= 1'b0; error <= 1'b0;
      exec_addr <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (boot_strap) begin
            st <= ST_HDR; spi_cs_n <= 1'b0; hidx <= '0; probing <= 1'b1; a24 <= 1'b0;
          end else begin
            skipped <= 1'b1; st <= ST_END;
          end
        end
        ST_HDR: if (bdone) begin
          if (hidx == hlast) begin
            st <= probing ? ST_PROBE : ST_REC; pcnt <= '0;
          end else hidx <= hidx + 2'd1;
        end
        ST_PROBE: if (bdone) begin
          pr   <= {pr[15:0], rxr};
          pcnt <= pcnt + 2'd1;
          if (pcnt == 2'd3) begin
            spi_cs_n <= 1'b1; gap <= '0; probing <= 1'b0;
            if ({pr, rxr} == SIGNATURE) begin
              a24 <= 1'b0; st <= ST_GAP;
            end else if ({pr[15:0], rxr} == SIGNATURE[31:8]) begin
              a24 <= 1'b1; st <= ST_GAP;
            end else begin
              skipped <= 1'b1; st <= ST_END;
            end
          end
        end
        ST_GAP: begin
          gap <= GAP_W'(gap + 1'b1);
          if (gap == GAP_W'(CS_GAP - 1)) begin
            spi_cs_n <= 1'b0; hidx <= '0; fld <= '0; nbytes <= '0; st <= ST_HDR;
          end
        end
        ST_REC: if (bdone) begin
          nbytes <= CNT_W'(nbytes + 1'b1);
          case (fld)
            3'd0: begin rtype <= rxr;       fld <= 3'd1; end
            3'd1: begin rlen[7:0]  <= rxr;  fld <= 3'd2; end
            3'd2: begin rlen[15:8] <= rxr;  fld <= 3'd3; end
            3'd3: begin alo <= rxr;         fld <= 3'd4; end
            3'd4: begin
              if (rtype == 8'd3) begin
                exec_addr <= {rxr, alo}; done <= 1'b1; spi_cs_n <= 1'b1; st <= ST_END;
              end else begin
                waddr <= {rxr, alo}; half <= 1'b0;
                fld   <= (rlen == 16'd0) ? 3'd0 : 3'd5;
              end
            end
            default: begin
              rlen <= rlen - 16'd1;
              if (rlen == 16'd1) fld <= 3'd0;
              if (rtype < 8'd3) begin
                if (!half) begin
                  lo <= rxr; half <= 1'b1;
                  if (rlen == 16'd1) begin
                    mem_we <= 1'b1; mem_data <= {8'h00, rxr}; mem_addr <= waddr;
                    mem_space <= rtype[1:0]; waddr <= waddr + 16'd1;
                  end
                end else begin
                  half <= 1'b0;
                  mem_we <= 1'b1; mem_data <= {rxr, lo}; mem_addr <= waddr;
                  mem_space <= rtype[1:0]; waddr <= waddr + 16'd1;
                end
              end
            end
          endcase
          if (!(fld == 3'd4 && rtype == 8'd3) && nbytes == CNT_W'(MAX_BYTES - 1)) begin
            error <= 1'b1; spi_cs_n <= 1'b1; st <= ST_END;
          end
        end
        default: ;
      endcase
    end
  end

  assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    skipped |-> spi_cs_n);
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_write_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_space != 2'd3);
  assert_write_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_no_write_after_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);
  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, skipped, error}));
  assert_outcome_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || skipped || error) |=> $stable({done, skipped, error, exec_addr}));
endmodule

// File: tb/spi_boot_loader_tb_top.sv
module spi_boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SIG = 32'h4254_4C44;
  localparam int NV = 12;
  // {strap, dev24, kind[2:0], outcome[1:0] (0 done,1 skip,2 error), exec[15:0]}
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 2'd0, 16'h1234},
    {1'b1, 1'b1, 3'd0, 2'd0, 16'h1234},
    {1'b1, 1'b0, 3'd1, 2'd0, 16'hBEEF},
    {1'b1, 1'b1, 3'd1, 2'd0, 16'hBEEF},
    {1'b1, 1'b0, 3'd2, 2'd0, 16'h0042},
    {1'b1, 1'b1, 3'd2, 2'd0, 16'h0042},
    {1'b1, 1'b0, 3'd3, 2'd1, 16'h0000},
    {1'b1, 1'b1, 3'd3, 2'd1, 16'h0000},
    {1'b0, 1'b0, 3'd0, 2'd1, 16'h0000},
    {1'b0, 1'b1, 3'd1, 2'd1, 16'h0000},
    {1'b1, 1'b0, 3'd4, 2'd2, 16'h0000},
    {1'b1, 1'b1, 3'd4, 2'd2, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, boot_strap = 1'b0, spi_miso = 1'b1;
  logic spi_sclk, spi_cs_n, spi_mosi, mem_we, done, skipped, error;
  logic [1:0] mem_space;
  logic [15:0] mem_addr, mem_data, exec_addr;

  int nchk = 0, nfail = 0;
  logic [7:0] eep [256];
  logic dev24 = 1'b0;
  int bitc = 0, ntx = 0;
  logic [31:0] hdr = '0;
  logic [23:0] base = '0;
  logic [7:0] tx_cmd [4];
  logic [23:0] tx_addr [4];
  int nw = 0, ew_n = 0;
  logic [1:0] w_sp [8], ew_sp [8];
  logic [15:0] w_ad [8], w_dt [8], ew_ad [8], ew_dt [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_boot_loader #(.SIGNATURE(SIG), .SCLK_HALF(2), .CS_GAP(3), .MAX_BYTES(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .boot_strap(boot_strap), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we), .done(done),
    .skipped(skipped), .error(error), .exec_addr(exec_addr));

  always @(spi_sclk or spi_cs_n) begin
    if (spi_cs_n !== 1'b0) begin
      bitc = 0; spi_miso = 1'b1;
    end else if (spi_sclk) begin
      hdr = {hdr[30:0], spi_mosi};
      bitc++;
      if (bitc == (dev24 ? 32 : 24)) begin
        base = dev24 ? hdr[23:0] : {8'h00, hdr[15:0]};
        if (ntx < 4) begin
          tx_cmd[ntx]  = dev24 ? hdr[31:24] : hdr[23:16];
          tx_addr[ntx] = base;
        end
        ntx++;
      end
    end else if (bitc >= (dev24 ? 32 : 24)) begin
      int idx;
      idx = bitc - (dev24 ? 32 : 24);
      spi_miso = eep[(int'(base) + idx / 8) & 255][7 - (idx % 8)];
    end
  end

  always @(negedge clk) if (rst_n && mem_we && nw < 8) begin
    w_sp[nw] = mem_space; w_ad[nw] = mem_addr; w_dt[nw] = mem_data; nw++;
  end else if (rst_n && mem_we) nw++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expw(input logic [1:0] sp, input logic [15:0] ad, input logic [15:0] dt);
    ew_sp[ew_n] = sp; ew_ad[ew_n] = ad; ew_dt[ew_n] = dt; ew_n++;
  endtask

  task automatic put(input int a, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4);
    eep[a] = b0; eep[a+1] = b1; eep[a+2] = b2; eep[a+3] = b3; eep[a+4] = b4;
  endtask

  task automatic build(input int kind);
    for (int i = 0; i < 256; i++) eep[i] = 8'hFF;
    ew_n = 0;
    eep[0] = SIG[31:24]; eep[1] = SIG[23:16]; eep[2] = SIG[15:8]; eep[3] = SIG[7:0];
    case (kind)
      0: begin
        put(4, 8'h00, 8'h04, 8'h00, 8'h00, 8'h01);
        eep[9] = 8'h11; eep[10] = 8'h22; eep[11] = 8'h33; eep[12] = 8'h44;
        put(13, 8'h03, 8'h00, 8'h00, 8'h34, 8'h12);
        expw(2'd0, 16'h0100, 16'h2211); expw(2'd0, 16'h0101, 16'h4433);
      end
      1: begin
        put(4, 8'h01, 8'h03, 8'h00, 8'h00, 8'h02);
        eep[9] = 8'hAA; eep[10] = 8'hBB; eep[11] = 8'hCC;
        put(12, 8'h02, 8'h02, 8'h00, 8'h00, 8'h03);
        eep[17] = 8'h01; eep[18] = 8'h02;
        put(19, 8'h03, 8'h09, 8'h00, 8'hEF, 8'hBE);
        expw(2'd1, 16'h0200, 16'hBBAA); expw(2'd1, 16'h0201, 16'h00CC);
        expw(2'd2, 16'h0300, 16'h0201);
      end
      2: begin
        put(4, 8'h07, 8'h03, 8'h00, 8'h00, 8'h00);
        eep[9] = 8'h03; eep[10] = 8'h00; eep[11] = 8'h00;
        put(12, 8'h00, 8'h00, 8'h00, 8'h50, 8'h00);
        put(17, 8'h00, 8'h02, 8'h00, 8'h10, 8'h00);
        eep[22] = 8'h5A; eep[23] = 8'hA5;
        put(24, 8'h03, 8'h00, 8'h00, 8'h42, 8'h00);
        expw(2'd0, 16'h0010, 16'hA55A);
      end
      3: eep[1] = 8'h58;
      default: put(4, 8'h07, 8'hC8, 8'h00, 8'h00, 8'h00);
    endcase
  endtask

  task automatic do_reset;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    ntx = 0; nw = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_wait(output bit ok);
    int t;
    t = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!(done || skipped || error) && t < 20000) begin @(negedge clk); t++; end
    ok = (t < 20000);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    bit ok;
    string rq;
    do_reset;
    chk("R11 reset flags", {29'd0, done, skipped, error}, 32'd0);
    chk("R11 reset spi", {30'd0, spi_cs_n, spi_sclk}, 32'd2);
    chk("R11 reset we", {31'd0, mem_we}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic strap_v;
      logic [2:0] kind;
      logic [1:0] oc;
      strap_v = VEC[v][22]; dev24 = VEC[v][21]; kind = VEC[v][20:18]; oc = VEC[v][17:16];
      build(int'(kind));
      boot_strap = strap_v;
      do_reset;
      run_wait(ok);
      if (!ok) begin nchk++; nfail++; $display("FAIL R11 watchdog vector %0d actual=hung expected=finish", v); end
      rq = (oc == 2'd0) ? "R9" : (oc == 2'd2) ? "R10" : strap_v ? "R5" : "R1";
      chk({rq, " outcome"}, {29'd0, done, skipped, error},
          (oc == 2'd0) ? 32'd4 : (oc == 2'd1) ? 32'd2 : 32'd1);
      chk({rq, " cs released"}, {31'd0, spi_cs_n}, 32'd1);
      if (!strap_v) chk("R1 no transaction", ntx, 0);
      else begin
        chk("R2 probe command", {24'd0, tx_cmd[0]}, 32'h03);
        chk("R2 probe address", {8'd0, tx_addr[0]}, 32'd0);
      end
      if (oc == 2'd0) begin
        chk("R9 start address", {16'd0, exec_addr}, {16'd0, VEC[v][15:0]});
        chk(dev24 ? "R4 transactions" : "R3 transactions", ntx, 2);
        chk(dev24 ? "R4 record address" : "R3 record address", {8'd0, tx_addr[1]}, 32'd4);
        chk(dev24 ? "R4 record command" : "R3 record command", {24'd0, tx_cmd[1]}, 32'h03);
      end
      if (oc == 2'd2) chk("R10 transactions", ntx, 2);
      chk((kind == 3'd2) ? "R8 write count" : "R6 write count", nw, (oc == 2'd0) ? ew_n : 0);
      if (oc == 2'd0)
        for (int k = 0; k < ew_n && k < nw; k++) begin
          chk("R6 space", {30'd0, w_sp[k]}, {30'd0, ew_sp[k]});
          chk("R6 address", {16'd0, w_ad[k]}, {16'd0, ew_ad[k]});
          chk("R7 data", {16'd0, w_dt[k]}, {16'd0, ew_dt[k]});
        end
    end

    build(0); dev24 = 1'b0; boot_strap = 1'b1;
    do_reset;
    run_wait(ok);
    chk("R9 directed done", {31'd0, done}, 32'd1);
    run_wait(ok);
    chk("R11 restart ignored ntx", ntx, 2);
    chk("R11 restart ignored nw", nw, 2);
    chk("R11 outcome held", {29'd0, done, skipped, error}, 32'd4);
    do_reset;
    chk("R11 reset clears", {29'd0, done, skipped, error}, 32'd0);
    chk("R11 reset exec", {16'd0, exec_addr}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule